// File: doc/BRIEF.md
# Hypervisor guest memory-access decoder

This block sits in the decode stage of a RISC-V core that has the hypervisor extension. It looks at one 32-bit instruction word each cycle and tells the pipeline whether the word is one of the loads or stores that reach guest memory on the hypervisor's behalf. For each such word it also decides whether the current privilege context may run it. When the access is permitted, the block requests two-stage (guest) address translation for that access alone, and it reports the access size, the signedness and whether execute rights stand in for read rights.

The same block prepares the data path at both ends of the access. On the store side it truncates the store operand to the access size and places it on byte lanes chosen by the low address bits, with matching byte enables. On the load side it takes the raw, right-justified memory data and sign- or zero-extends it to the register width. Address translation, the memory system and the register file are outside it. Every output is registered, so each result appears one clock after the inputs that produced it.

Top module: `hgl_top`

## Requirements
- R1: A word is in the group only if bits 6:0 equal 1110011 and bits 14:12 equal 100. Any other word gives hit_o=0 and illegal_o=0, and every other output is zero.
- R2: Loads use funct7 (bits 31:25) 0110000, 0110010, 0110100 and 0110110 for byte, halfword, word and doubleword, reported on size_o as 0, 1, 2 and 3. The rs2 field (bits 24:20) selects the variant: 00000 is signed (signed_o=1), 00001 is unsigned and 00011 is the execute-check unsigned load. Any other rs2 value is outside the group.
- R3: The execute-check variant exists only for halfword and word, and there it sets xperm_o=1. With a byte or doubleword funct7 and rs2=00011 the word is outside the group, and so is the unsigned doubleword load.
- R4: Stores use funct7 0110001, 0110011, 0110101 and 0110111 for byte, halfword, word and doubleword, with is_store_o=1. The rd field (bits 11:7) must be 00000, or the word is outside the group. rs1_o carries the address register and rs2_o the data register; for a store rd_o is 0, and for a load rs2_o is 0.
- R5: With XLEN=32 the unsigned word load, the doubleword load and the doubleword store give hit_o=1 and illegal_o=1.
- R6: A group word is permitted when priv_i=11 (machine), when priv_i=01 (supervisor) and virt_i=0, or when priv_i=00 (user), virt_i=0 and hstat_i bit 9 is 1. In every other case, including priv_i=10, illegal_o=1.
- R7: When hyp_en_i=0, every group word gives illegal_o=1.
- R8: two_stage_o is 1 exactly when hit_o=1 and illegal_o=0.
- R9: A permitted signed load sign-extends bit 7, 15 or 31 of mem_rdata_i to XLEN. A doubleword load passes mem_rdata_i through unchanged.
- R10: Permitted unsigned and execute-check loads zero-extend. ldres_o is zero for every word that is not a permitted load.
- R11: A permitted store outputs the low 1, 2, 4 or 8 bytes of st_data_i shifted up by the lane offset in addr_lo_i. wstrb_o covers the same lanes, and lanes past the top are dropped. wdata_o and wstrb_o are zero for every word that is not a permitted store.
- R12: All outputs change one clock after their inputs, and synchronous reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization mode active |
| hstat_i | input | XLEN | Hypervisor status register (bit 9 grants user access) |
| hyp_en_i | input | 1 | Hypervisor extension enabled |
| addr_lo_i | input | 3 | Low bits of the access address (byte lane offset) |
| st_data_i | input | XLEN | Store operand |
| mem_rdata_i | input | XLEN | Raw right-justified load data |
| hit_o | output | 1 | Word belongs to the group |
| illegal_o | output | 1 | Illegal-instruction exception |
| is_store_o | output | 1 | Access is a store |
| size_o | output | 2 | Access size code |
| signed_o | output | 1 | Signed load |
| xperm_o | output | 1 | Translation checks execute rights |
| two_stage_o | output | 1 | Guest two-stage translation request |
| rd_o | output | 5 | Destination register |
| rs1_o | output | 5 | Address register |
| rs2_o | output | 5 | Store data register |
| wdata_o | output | XLEN | Lane-aligned store data |
| wstrb_o | output | XLEN/8 | Byte enables |
| ldres_o | output | XLEN | Extended load result |

## Verification
The bench builds two copies side by side: one with XLEN=64 and one with XLEN=32, both driven from the same inputs. The 64-bit copy reaches the full encoding table, doubleword stores across all eight lanes and extension up to 64 bits. The 32-bit copy brings the width-dependent rejection of the unsigned word load and the doubleword accesses within reach, along with word sign extension that fills the whole register.

// File: rtl/hgl_pkg.sv
package hgl_pkg;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;

  localparam logic [6:0] OPC_SYS    = 7'b1110011;
  localparam logic [2:0] F3_GUEST   = 3'b100;
  localparam logic [3:0] F7_FAMILY  = 4'b0110;  // funct7[6:3]; [2:1] size, [0] store

  localparam logic [4:0] VAR_SGN    = 5'b00000;
  localparam logic [4:0] VAR_UNS    = 5'b00001;
  localparam logic [4:0] VAR_XCHK   = 5'b00011;

  localparam logic [1:0] PRV_USER   = 2'b00;
  localparam logic [1:0] PRV_SUPER  = 2'b01;
  localparam logic [1:0] PRV_MACH   = 2'b11;

  localparam int         UACC_BIT   = 9;

  typedef struct packed {
    logic      hit;
    logic      store;
    acc_size_e size;
    logic      sgn;
    logic      xperm;
    logic      wide_only;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
  } hdec_t;

endpackage

// File: rtl/hgl_field_decode.sv
module hgl_field_decode
  import hgl_pkg::*;
(
  input  logic [31:0] insn,
  output hdec_t       dec
);
  logic [6:0] f7;
  logic [4:0] var_f;
  logic [4:0] rd_f;
  logic       base_ok;
  acc_size_e  sz;

  assign f7      = insn[31:25];
  assign var_f   = insn[24:20];
  assign rd_f    = insn[11:7];
  assign sz      = acc_size_e'(f7[2:1]);
  assign base_ok = (insn[6:0] == OPC_SYS) && (insn[14:12] == F3_GUEST) &&
                   (f7[6:3] == F7_FAMILY);

  always_comb begin
    dec           = '0;
    dec.size      = sz;
    dec.rs1       = insn[19:15];
    if (base_ok) begin
      if (f7[0]) begin
        dec.hit       = (rd_f == 5'd0);
        dec.store     = 1'b1;
        dec.wide_only = (sz == SZ_D);
        dec.rs2       = var_f;
      end else begin
        dec.rd = rd_f;
        unique case (var_f)
          VAR_SGN: begin
            dec.hit       = 1'b1;
            dec.sgn       = 1'b1;
            dec.wide_only = (sz == SZ_D);
          end
          VAR_UNS: begin
            dec.hit       = (sz != SZ_D);
            dec.wide_only = (sz == SZ_W);
          end
          VAR_XCHK: begin
            dec.hit   = (sz == SZ_H) || (sz == SZ_W);
            dec.xperm = 1'b1;
          end
          default: dec.hit = 1'b0;
        endcase
      end
    end
    if (!dec.hit) dec = '0;
  end
endmodule

// File: rtl/hgl_priv_gate.sv
module hgl_priv_gate
  import hgl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic       hyp_en,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       uacc,
  input  logic       wide_only,
  output logic       permit
);
  localparam bit NARROW = (XLEN == 32);

  logic ctx_ok;

  always_comb begin
    unique case (priv)
      PRV_MACH:  ctx_ok = 1'b1;
      PRV_SUPER: ctx_ok = !virt;
      PRV_USER:  ctx_ok = !virt && uacc;
      default:   ctx_ok = 1'b0;
    endcase
  end

  assign permit = hyp_en && ctx_ok && !(NARROW && wide_only);
endmodule

// File: rtl/hgl_load_extend.sv
module hgl_load_extend
  import hgl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  acc_size_e       size,
  input  logic            sgn,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] keep;
  logic            top;

  always_comb begin
    unique case (size)
      SZ_B:    begin keep = XLEN'(8'hFF);         top = raw[7];  end
      SZ_H:    begin keep = XLEN'(16'hFFFF);      top = raw[15]; end
      SZ_W:    begin keep = XLEN'(32'hFFFF_FFFF); top = raw[31]; end
      default: begin keep = '1;                   top = 1'b0;    end
    endcase
    res = (raw & keep) | ((sgn && top) ? ~keep : '0);
  end
endmodule

// File: rtl/hgl_store_align.sv
module hgl_store_align
  import hgl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   src,
  input  acc_size_e         size,
  input  logic [2:0]        offs,
  output logic [XLEN-1:0]   data,
  output logic [XLEN/8-1:0] strb
);
  localparam int NB = XLEN / 8;
  localparam int LW = $clog2(NB);

  logic [LW-1:0] shift;
  int            nbytes;

  assign shift  = offs[LW-1:0];
  assign nbytes = 1 << size;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_e;
    always_comb begin
      int rel;
      rel    = i - int'(shift);
      lane_e = 1'b0;
      lane_d = 8'h00;
      if (rel >= 0 && rel < nbytes) begin
        lane_e = 1'b1;
        lane_d = src[rel*8 +: 8];
      end
    end
    assign data[i*8 +: 8] = lane_d;
    assign strb[i]        = lane_e;
  end
endmodule

// File: rtl/hgl_top.sv
module hgl_top
  import hgl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic [XLEN-1:0]   hstat_i,
  input  logic              hyp_en_i,
  input  logic [2:0]        addr_lo_i,
  input  logic [XLEN-1:0]   st_data_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              hit_o,
  output logic              illegal_o,
  output logic              is_store_o,
  output logic [1:0]        size_o,
  output logic              signed_o,
  output logic              xperm_o,
  output logic              two_stage_o,
  output logic [4:0]        rd_o,
  output logic [4:0]        rs1_o,
  output logic [4:0]        rs2_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic [XLEN/8-1:0] wstrb_o,
  output logic [XLEN-1:0]   ldres_o
);
  localparam int NB = XLEN / 8;

  hdec_t           dec;
  logic            permit;
  logic            go;
  logic [XLEN-1:0] ext_d;
  logic [XLEN-1:0] al_d;
  logic [NB-1:0]   al_s;

  hgl_field_decode u_dec (.insn(insn_i), .dec(dec));

  hgl_priv_gate #(.XLEN(XLEN)) u_gate (
    .hyp_en(hyp_en_i), .priv(priv_i), .virt(virt_i),
    .uacc(hstat_i[UACC_BIT]), .wide_only(dec.wide_only), .permit(permit)
  );

  hgl_load_extend #(.XLEN(XLEN)) u_ext (
    .raw(mem_rdata_i), .size(dec.size), .sgn(dec.sgn), .res(ext_d)
  );

  hgl_store_align #(.XLEN(XLEN)) u_align (
    .src(st_data_i), .size(dec.size), .offs(addr_lo_i), .data(al_d), .strb(al_s)
  );

  assign go = dec.hit && permit;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o       <= 1'b0;
      illegal_o   <= 1'b0;
      is_store_o  <= 1'b0;
      size_o      <= 2'd0;
      signed_o    <= 1'b0;
      xperm_o     <= 1'b0;
      two_stage_o <= 1'b0;
      rd_o        <= 5'd0;
      rs1_o       <= 5'd0;
      rs2_o       <= 5'd0;
      wdata_o     <= '0;
      wstrb_o     <= '0;
      ldres_o     <= '0;
    end else begin
      hit_o       <= dec.hit;
      illegal_o   <= dec.hit && !permit;
      is_store_o  <= dec.store;
      size_o      <= dec.size;
      signed_o    <= dec.sgn;
      xperm_o     <= dec.xperm;
      two_stage_o <= go;
      rd_o        <= dec.rd;
      rs1_o       <= dec.rs1;
      rs2_o       <= dec.rs2;
      wdata_o     <= (go && dec.store)  ? al_d  : '0;
      wstrb_o     <= (go && dec.store)  ? al_s  : '0;
      ldres_o     <= (go && !dec.store) ? ext_d : '0;
    end
  end
endmodule

// File: rtl/hgl_checker.sv
module hgl_checker #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        priv_i,
  input logic              virt_i,
  input logic              uacc_i,
  input logic              hyp_en_i,
  input logic              hit_o,
  input logic              illegal_o,
  input logic              is_store_o,
  input logic [1:0]        size_o,
  input logic              signed_o,
  input logic              xperm_o,
  input logic              two_stage_o,
  input logic [XLEN/8-1:0] wstrb_o,
  input logic [XLEN-1:0]   ldres_o
);
  assert_illegal_needs_hit_R1: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> hit_o);

  assert_xperm_half_word_R3: assert property (@(posedge clk) disable iff (rst)
    xperm_o |-> (!is_store_o && !signed_o && (size_o == 2'd1 || size_o == 2'd2)));

  assert_priv_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !illegal_o) |-> ($past(priv_i) == 2'b11 ||
      ($past(priv_i) == 2'b01 && !$past(virt_i)) ||
      ($past(priv_i) == 2'b00 && !$past(virt_i) && $past(uacc_i))));

  assert_ext_off_traps_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !$past(hyp_en_i)) |-> illegal_o);

  assert_two_stage_only_legal_R8: assert property (@(posedge clk) disable iff (rst)
    two_stage_o |-> (hit_o && !illegal_o));

  assert_byte_sign_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (two_stage_o && !is_store_o && signed_o && size_o == 2'd0) |->
      ((&ldres_o[XLEN-1:7]) || !(|ldres_o[XLEN-1:7])));

  assert_no_strobe_unless_store_R11: assert property (@(posedge clk) disable iff (rst)
    !(two_stage_o && is_store_o) |-> (wstrb_o == '0));

  assert_byte_store_one_lane_R11: assert property (@(posedge clk) disable iff (rst)
    (two_stage_o && is_store_o && size_o == 2'd0) |-> $onehot0(wstrb_o));

  if (XLEN == 32) begin : g_narrow
    assert_narrow_no_wide_R5: assert property (@(posedge clk) disable iff (rst)
      two_stage_o |-> (size_o != 2'd3 &&
        !(size_o == 2'd2 && !is_store_o && !signed_o && !xperm_o)));
  end
endmodule

bind hgl_top hgl_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .priv_i(priv_i), .virt_i(virt_i),
  .uacc_i(hstat_i[9]), .hyp_en_i(hyp_en_i), .hit_o(hit_o),
  .illegal_o(illegal_o), .is_store_o(is_store_o), .size_o(size_o),
  .signed_o(signed_o), .xperm_o(xperm_o), .two_stage_o(two_stage_o),
  .wstrb_o(wstrb_o), .ldres_o(ldres_o)
);

// File: tb/hgl_top_test.sv
module hgl_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = 32'h0;
  logic [1:0]  priv = 2'b11;
  logic        virt = 1'b0;
  logic [63:0] hstat = 64'h0;
  logic        hen = 1'b1;
  logic [2:0]  alo = 3'd0;
  logic [63:0] sdat = 64'h0;
  logic [63:0] rdat = 64'h0;

  logic        hit, ill, st, sg, xp, ts;
  logic [1:0]  sz;
  logic [4:0]  rd, rs1, rs2;
  logic [63:0] wd, lr;
  logic [7:0]  ws;

  logic        hit32, ill32, st32, sg32, xp32, ts32;
  logic [1:0]  sz32;
  logic [4:0]  rd32, rs1_32, rs2_32;
  logic [31:0] wd32, lr32;
  logic [3:0]  ws32;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  hgl_top #(.XLEN(64)) uut (
    .clk(clk), .rst(rst), .insn_i(insn), .priv_i(priv), .virt_i(virt),
    .hstat_i(hstat), .hyp_en_i(hen), .addr_lo_i(alo), .st_data_i(sdat),
    .mem_rdata_i(rdat), .hit_o(hit), .illegal_o(ill), .is_store_o(st),
    .size_o(sz), .signed_o(sg), .xperm_o(xp), .two_stage_o(ts), .rd_o(rd),
    .rs1_o(rs1), .rs2_o(rs2), .wdata_o(wd), .wstrb_o(ws), .ldres_o(lr)
  );

  hgl_top #(.XLEN(32)) uut_x32 (
    .clk(clk), .rst(rst), .insn_i(insn), .priv_i(priv), .virt_i(virt),
    .hstat_i(hstat[31:0]), .hyp_en_i(hen), .addr_lo_i(alo), .st_data_i(sdat[31:0]),
    .mem_rdata_i(rdat[31:0]), .hit_o(hit32), .illegal_o(ill32), .is_store_o(st32),
    .size_o(sz32), .signed_o(sg32), .xperm_o(xp32), .two_stage_o(ts32), .rd_o(rd32),
    .rs1_o(rs1_32), .rs2_o(rs2_32), .wdata_o(wd32), .wstrb_o(ws32), .ldres_o(lr32)
  );

  function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] r2, logic [4:0] r1, logic [4:0] d);
    return {f7, r2, r1, 3'b100, d, 7'b1110011};
  endfunction

  // insn, priv, virt, uacc, en | hit, ill, store, size, signed, xperm
  function automatic logic [43:0] vec(logic [31:0] w, logic [1:0] p, logic v, logic u, logic e,
                                      logic h, logic i, logic s, logic [1:0] z, logic g, logic x);
    return {w, p, v, u, e, h, i, s, z, g, x};
  endfunction

  localparam int NV = 26;
  localparam logic [43:0] VEC [NV] = '{
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd0, 1, 0), // R2 byte signed
    vec(enc(7'b0110000, 5'd1, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd0, 0, 0), // R2 byte unsigned
    vec(enc(7'b0110010, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd1, 1, 0), // R2 half signed
    vec(enc(7'b0110010, 5'd1, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd1, 0, 0), // R2 half unsigned
    vec(enc(7'b0110010, 5'd3, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd1, 0, 1), // R3 half xcheck
    vec(enc(7'b0110100, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd2, 1, 0), // R2 word signed
    vec(enc(7'b0110100, 5'd1, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd2, 0, 0), // R2 word unsigned
    vec(enc(7'b0110100, 5'd3, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd2, 0, 1), // R3 word xcheck
    vec(enc(7'b0110110, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1, 1, 0, 0, 2'd3, 1, 0), // R2 double
    vec(enc(7'b0110000, 5'd3, 5'd3, 5'd5), 2'b11, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0), // R3 byte xcheck absent
    vec(enc(7'b0110110, 5'd3, 5'd3, 5'd5), 2'b11, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0), // R3 double xcheck absent
    vec(enc(7'b0110001, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1, 1, 0, 1, 2'd0, 0, 0), // R4 byte store
    vec(enc(7'b0110011, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1, 1, 0, 1, 2'd1, 0, 0), // R4 half store
    vec(enc(7'b0110101, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1, 1, 0, 1, 2'd2, 0, 0), // R4 word store
    vec(enc(7'b0110111, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1, 1, 0, 1, 2'd3, 0, 0), // R4 double store
    vec(enc(7'b0110001, 5'd7, 5'd3, 5'd1), 2'b11, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0), // R4 rd nonzero
    vec({7'b0110000, 5'd0, 5'd3, 3'b000, 5'd5, 7'b1110011}, 2'b11, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0), // R1 funct3
    vec({7'b0110000, 5'd0, 5'd3, 3'b100, 5'd5, 7'b0000011}, 2'b11, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0), // R1 opcode
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b01, 0, 0, 1, 1, 0, 0, 2'd0, 1, 0), // R6 S, not virt
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b01, 1, 0, 1, 1, 1, 0, 2'd0, 1, 0), // R6 S, virt
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b00, 0, 1, 1, 1, 0, 0, 2'd0, 1, 0), // R6 U, uacc
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b00, 0, 0, 1, 1, 1, 0, 2'd0, 1, 0), // R6 U, no uacc
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b00, 1, 1, 1, 1, 1, 0, 2'd0, 1, 0), // R6 U, virt
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b10, 0, 1, 1, 1, 1, 0, 2'd0, 1, 0), // R6 reserved priv
    vec(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b11, 0, 1, 0, 1, 1, 0, 2'd0, 1, 0), // R7 ext off
    vec(enc(7'b0110000, 5'd2, 5'd3, 5'd5), 2'b11, 0, 0, 1, 0, 0, 0, 2'd0, 0, 0)  // R2 bad variant
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic apply(input logic [31:0] w, input logic [1:0] p, input logic v,
                       input logic u, input logic e);
    @(negedge clk);
    insn = w; priv = p; virt = v; hstat = {54'h0, u, 9'h0}; hen = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12 reset clears outputs even with a legal word applied
    insn = enc(7'b0110000, 5'd0, 5'd3, 5'd5);
    rdat = 64'hFF;
    repeat (3) @(posedge clk);
    #1;
    eq("R12 reset hit", hit, 0);
    eq("R12 reset two_stage", ts, 0);
    eq("R12 reset ldres", lr, 0);
    @(negedge clk); rst = 1'b0;
    #1;
    eq("R12 no change before edge", hit, 0);
    @(posedge clk); #1;
    eq("R12 one-clock latency", hit, 1);

    rdat = 64'h0;
    for (int k = 0; k < NV; k++) begin
      logic [43:0] v;
      v = VEC[k];
      apply(v[43:12], v[11:10], v[9], v[8], v[7]);
      eq($sformatf("R1 hit v%0d", k), hit, v[6]);
      eq($sformatf("R6 illegal v%0d", k), ill, v[5]);
      eq($sformatf("R4 store v%0d", k), st, v[4]);
      eq($sformatf("R2 size v%0d", k), sz, v[3:2]);
      eq($sformatf("R2 signed v%0d", k), sg, v[1]);
      eq($sformatf("R3 xperm v%0d", k), xp, v[0]);
      eq($sformatf("R8 two_stage v%0d", k), ts, v[6] & ~v[5]);
    end

    // R4 register fields
    apply(enc(7'b0110101, 5'd9, 5'd4, 5'd0), 2'b11, 0, 0, 1);
    eq("R4 store rs1", rs1, 4); eq("R4 store rs2", rs2, 9); eq("R4 store rd", rd, 0);
    apply(enc(7'b0110100, 5'd1, 5'd6, 5'd17), 2'b11, 0, 0, 1);
    eq("R4 load rd", rd, 17); eq("R4 load rs1", rs1, 6); eq("R4 load rs2", rs2, 0);

    // R5 narrow width gating
    apply(enc(7'b0110100, 5'd1, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R5 x32 word unsigned hit", hit32, 1); eq("R5 x32 word unsigned ill", ill32, 1);
    apply(enc(7'b0110110, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R5 x32 double load ill", ill32, 1); eq("R5 x64 double load ill", ill, 0);
    apply(enc(7'b0110111, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1);
    eq("R5 x32 double store ill", ill32, 1); eq("R5 x32 double store strb", ws32, 0);
    apply(enc(7'b0110100, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R5 x32 word signed legal", ill32, 0);

    // R9 / R10 extension
    rdat = 64'h1234_5678_9ABC_DE80;
    apply(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R9 byte sign", lr, 64'hFFFF_FFFF_FFFF_FF80);
    apply(enc(7'b0110000, 5'd1, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R10 byte zero", lr, 64'h80);
    rdat = 64'hAAAA_AAAA_8000_8001;
    apply(enc(7'b0110010, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R9 half sign", lr, 64'hFFFF_FFFF_FFFF_8001);
    eq("R9 x32 half sign", lr32, 32'hFFFF_8001);
    apply(enc(7'b0110010, 5'd3, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R10 half xcheck zero", lr, 64'h8001);
    apply(enc(7'b0110100, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R9 word sign", lr, 64'hFFFF_FFFF_8000_8001);
    eq("R9 x32 word", lr32, 32'h8000_8001);
    apply(enc(7'b0110100, 5'd3, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R10 word xcheck zero", lr, 64'h8000_8001);
    apply(enc(7'b0110110, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R9 double pass", lr, 64'hAAAA_AAAA_8000_8001);
    apply(enc(7'b0110000, 5'd0, 5'd3, 5'd5), 2'b00, 0, 0, 1);
    eq("R10 illegal load result zero", lr, 0);

    // R11 store alignment
    sdat = 64'h0123_4567_89AB_CDEF;
    alo = 3'd3;
    apply(enc(7'b0110001, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1);
    eq("R11 byte data", wd, 64'hEF00_0000); eq("R11 byte strb", ws, 8'h08);
    eq("R11 x32 byte strb", ws32, 4'h8);
    alo = 3'd2;
    apply(enc(7'b0110011, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1);
    eq("R11 half data", wd, 64'hCDEF_0000); eq("R11 half strb", ws, 8'h0C);
    alo = 3'd4;
    apply(enc(7'b0110101, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1);
    eq("R11 word data", wd, 64'h89AB_CDEF_0000_0000); eq("R11 word strb", ws, 8'hF0);
    alo = 3'd0;
    apply(enc(7'b0110111, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1);
    eq("R11 double data", wd, 64'h0123_4567_89AB_CDEF); eq("R11 double strb", ws, 8'hFF);
    alo = 3'd6;
    apply(enc(7'b0110101, 5'd7, 5'd3, 5'd0), 2'b11, 0, 0, 1);
    eq("R11 word past top strb", ws, 8'hC0); eq("R11 word past top data", wd, 64'hCDEF_0000_0000_0000);
    apply(enc(7'b0110101, 5'd7, 5'd3, 5'd0), 2'b00, 0, 0, 1);
    eq("R11 illegal store strb", ws, 0); eq("R11 illegal store data", wd, 0);
    apply(enc(7'b0110100, 5'd0, 5'd3, 5'd5), 2'b11, 0, 0, 1);
    eq("R11 load no strb", ws, 0);

    // R7 with a store, R1 with a foreign word
    apply(enc(7'b0110011, 5'd7, 5'd3, 5'd0), 2'b11, 0, 1, 0);
    eq("R7 store ext off", ill, 1); eq("R7 store ext off strb", ws, 0);
    apply(32'h0000_0013, 2'b11, 0, 0, 1);
    eq("R1 foreign ill", ill, 0); eq("R1 foreign rs1", rs1, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule